// File: doc/BRIEF.md
# Reed-Solomon 9-bit symbol error patcher

This block holds one 512-byte data block in a local byte RAM and applies the corrections that an external Reed-Solomon decoder reports for it. The decoder works on 9-bit symbols that are packed back to back across byte boundaries. It reports up to four error slots. Each slot is a 1-based symbol index and a 9-bit error mask. A count field says how many slots are in use, and a flag marks the block as uncorrectable. This block does not compute syndromes or error locations. It does not fetch parity either.

A host fills the RAM through a plain byte port while the block is idle, then pulses `start` together with the decoder report. The block takes each used slot in turn, from the highest-numbered slot down to slot 0. For each slot it finds the one or two bytes that hold the symbol, reads them, XORs the mask into the right bit positions, and writes both bytes back. When the last slot is finished it raises `done` for one cycle, together with a status showing how many corrections were applied or that the block was uncorrectable. The host then reads the corrected data back through the same byte port.

Top module: `rsp_patcher`

## Requirements
- R1: Bit b (0..8) of the mask for symbol index k is XORed into global data bit g = 9*(k-1)+b. Global bit g is bit g%8 of byte g/8. Bytes that the mask does not touch keep their value.
- R2: When a symbol extends past byte 511, its bits with g >= 4096 are dropped. The bits that fall inside the block are still applied. Symbol 456 therefore changes only bit 7 of byte 511, using mask bit 0.
- R3: A slot with index 0 is ignored. A slot whose first bit 9*(k-1) lies at or beyond 4096 is also ignored. An ignored slot changes no byte.
- R4: Only slots count-1 down to 0 are processed, in that order. Slots at or above the count are ignored. A count of 0, or a count greater than 4, applies no corrections.
- R5: When the uncorrectable flag is set at start, the RAM is left unchanged, `stat_uncor` reads 1 and `stat_cnt` reads 0.
- R6: `done` is high for exactly one cycle. It rises L clock edges after the edge that accepts `start`, where L = 1 + 6*(number of applied slots) + (number of ignored slots within the count). `busy` falls on the same edge that `done` rises.
- R7: When `done` rises, `stat_cnt` equals the number of corrections applied. It excludes ignored slots and is never more than 4.
- R8: While `busy` is high, `start` and host writes are ignored. While idle, a host write lands on the clock edge where it is sampled, and read data appears one edge after the address is sampled.
- R9: After reset, `busy`, `done`, `stat_cnt` and `stat_uncor` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host byte write enable (idle only) |
| host_addr | input | 9 | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered read byte |
| start | input | 1 | Begin patching with the report below |
| err_cnt | input | 3 | Number of used slots |
| err_uncor | input | 1 | Decoder reports uncorrectable block |
| err_idx | input | 40 | Four 10-bit symbol indices, slot s at bits 10s+9..10s |
| err_mask | input | 36 | Four 9-bit masks, slot s at bits 9s+8..9s |
| busy | output | 1 | Patching in progress |
| done | output | 1 | One-cycle completion pulse |
| stat_cnt | output | 3 | Corrections applied in the last run |
| stat_uncor | output | 1 | Last run was flagged uncorrectable |

## Verification
Each result has a fixed due cycle. `done` arrives 1 + 6*(applied slots) + (ignored slots) cycles after the accepting edge. RAM read data arrives one cycle after its address. The bench computes the expected latency of every run from the slot indices and counts falling edges from the accepting edge. It requires `done` at exactly that count and low on the next edge, and it reads the status in that same cycle. Every symbol index from 0 to 520 is swept against a bench-side bit model built from the 9*(k-1)+b mapping. The whole RAM is read back at one-cycle read latency and compared byte for byte.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_RLO,
    ST_RHI,
    ST_MOD,
    ST_WLO,
    ST_WHI,
    ST_FIN
  } rsp_state_e;
endpackage

// File: rtl/rsp_byte_ram.sv
module rsp_byte_ram #(
  parameter int DEPTH = 512,
  parameter int AW    = 9,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // single port, read-first, synchronous read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/rsp_locator.sv
module rsp_locator #(
  parameter int BLK_BYTES = 512,
  parameter int SYM_W     = 9,
  parameter int IDX_W     = 10,
  parameter int AW        = 9
) (
  input  logic [IDX_W-1:0] sym_idx,
  output logic             loc_vld,
  output logic             loc_has_hi,
  output logic [AW-1:0]    lo_addr,
  output logic [AW-1:0]    hi_addr,
  output logic [2:0]       bit_shift
);
  localparam int PW = IDX_W + $clog2(SYM_W) + 1;

  logic [PW-1:0] bit_pos;
  logic [PW-1:0] byte_raw;
  logic [PW-1:0] byte_sel;

  always_comb begin
    bit_pos  = PW'(sym_idx) * PW'(SYM_W);
    byte_raw = bit_pos >> 3;
    if (bit_pos[2:0] == 3'd0) begin
      byte_sel  = byte_raw - PW'(1);
      bit_shift = 3'd7;
    end else begin
      byte_sel  = byte_raw;
      bit_shift = bit_pos[2:0] - 3'd1;
    end
    loc_vld    = (sym_idx != '0) && (byte_sel <= PW'(BLK_BYTES));
    loc_has_hi = byte_sel < PW'(BLK_BYTES);
    hi_addr    = byte_sel[AW-1:0];
    lo_addr    = byte_sel[AW-1:0] - AW'(1);
  end
endmodule

// File: rtl/rsp_seq.sv
module rsp_seq
  import rsp_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int SYM_W = 9,
  parameter int AW    = 9,
  parameter int CNT_W = 3,
  parameter int SW    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             uncor_in,
  output logic             accept,
  output logic [SW-1:0]    slot,
  input  logic             cur_vld,
  input  logic             cur_has_hi,
  input  logic [AW-1:0]    cur_lo,
  input  logic [AW-1:0]    cur_hi,
  input  logic [2:0]       cur_shift,
  input  logic [SYM_W-1:0] cur_mask,
  input  logic [7:0]       ram_rdata,
  output logic             eng_we,
  output logic [AW-1:0]    eng_addr,
  output logic [7:0]       eng_wdata,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] stat_cnt,
  output logic             stat_uncor
);
  rsp_state_e       state;
  logic [CNT_W-1:0] applied;
  logic             uncor_q;
  logic [7:0]       lo_q;
  logic [15:0]      word_q;
  logic [15:0]      flip;
  logic [7:0]       hi_byte;

  assign accept  = start && (state == ST_IDLE);
  assign flip    = 16'(cur_mask) << cur_shift;
  assign hi_byte = cur_has_hi ? ram_rdata : 8'h00;

  always_comb begin
    eng_we    = 1'b0;
    eng_addr  = cur_lo;
    eng_wdata = word_q[7:0];
    case (state)
      ST_RHI: eng_addr = cur_hi;
      ST_WLO: eng_we   = 1'b1;
      ST_WHI: begin
        eng_we    = cur_has_hi;
        eng_addr  = cur_hi;
        eng_wdata = word_q[15:8];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      slot       <= '0;
      applied    <= '0;
      uncor_q    <= 1'b0;
      lo_q       <= '0;
      word_q     <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      stat_cnt   <= '0;
      stat_uncor <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          busy    <= 1'b1;
          applied <= '0;
          uncor_q <= uncor_in;
          if (uncor_in || cnt_in == '0 || cnt_in > CNT_W'(SLOTS)) begin
            state <= ST_FIN;
          end else begin
            slot  <= SW'(cnt_in - CNT_W'(1));
            state <= ST_SLOT;
          end
        end
        ST_SLOT: begin
          if (cur_vld) begin
            applied <= applied + CNT_W'(1);
            state   <= ST_RLO;
          end else if (slot == '0) begin
            state <= ST_FIN;
          end else begin
            slot <= slot - SW'(1);
          end
        end
        ST_RLO: state <= ST_RHI;
        ST_RHI: begin
          lo_q  <= ram_rdata;
          state <= ST_MOD;
        end
        ST_MOD: begin
          word_q <= {hi_byte, lo_q} ^ flip;
          state  <= ST_WLO;
        end
        ST_WLO: state <= ST_WHI;
        ST_WHI: begin
          if (slot == '0) begin
            state <= ST_FIN;
          end else begin
            slot  <= slot - SW'(1);
            state <= ST_SLOT;
          end
        end
        ST_FIN: begin
          busy       <= 1'b0;
          done       <= 1'b1;
          stat_cnt   <= applied;
          stat_uncor <= uncor_q;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rsp_patcher.sv
module rsp_patcher #(
  parameter int BLK_BYTES = 512,
  parameter int SYM_W     = 9,
  parameter int IDX_W     = 10,
  parameter int SLOTS     = 4,
  localparam int AW       = $clog2(BLK_BYTES),
  localparam int CNT_W    = $clog2(SLOTS + 1),
  localparam int SW       = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   host_we,
  input  logic [AW-1:0]          host_addr,
  input  logic [7:0]             host_wdata,
  output logic [7:0]             host_rdata,
  input  logic                   start,
  input  logic [CNT_W-1:0]       err_cnt,
  input  logic                   err_uncor,
  input  logic [SLOTS*IDX_W-1:0] err_idx,
  input  logic [SLOTS*SYM_W-1:0] err_mask,
  output logic                   busy,
  output logic                   done,
  output logic [CNT_W-1:0]       stat_cnt,
  output logic                   stat_uncor
);
  logic                   accept;
  logic [SW-1:0]          slot;
  logic [SLOTS*IDX_W-1:0] idx_q;
  logic [SLOTS*SYM_W-1:0] mask_q;

  logic             loc_vld    [SLOTS];
  logic             loc_has_hi [SLOTS];
  logic [AW-1:0]    loc_lo     [SLOTS];
  logic [AW-1:0]    loc_hi     [SLOTS];
  logic [2:0]       loc_shift  [SLOTS];
  logic [SYM_W-1:0] loc_mask   [SLOTS];

  logic          eng_we;
  logic [AW-1:0] eng_addr;
  logic [7:0]    eng_wdata;
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [7:0]    ram_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      mask_q <= '0;
    end else if (accept) begin
      idx_q  <= err_idx;
      mask_q <= err_mask;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    rsp_locator #(
      .BLK_BYTES(BLK_BYTES), .SYM_W(SYM_W), .IDX_W(IDX_W), .AW(AW)
    ) loc_i (
      .sym_idx   (idx_q[s*IDX_W +: IDX_W]),
      .loc_vld   (loc_vld[s]),
      .loc_has_hi(loc_has_hi[s]),
      .lo_addr   (loc_lo[s]),
      .hi_addr   (loc_hi[s]),
      .bit_shift (loc_shift[s])
    );
    assign loc_mask[s] = mask_q[s*SYM_W +: SYM_W];
  end

  rsp_seq #(
    .SLOTS(SLOTS), .SYM_W(SYM_W), .AW(AW), .CNT_W(CNT_W), .SW(SW)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cnt_in    (err_cnt),
    .uncor_in  (err_uncor),
    .accept    (accept),
    .slot      (slot),
    .cur_vld   (loc_vld[slot]),
    .cur_has_hi(loc_has_hi[slot]),
    .cur_lo    (loc_lo[slot]),
    .cur_hi    (loc_hi[slot]),
    .cur_shift (loc_shift[slot]),
    .cur_mask  (loc_mask[slot]),
    .ram_rdata (host_rdata),
    .eng_we    (eng_we),
    .eng_addr  (eng_addr),
    .eng_wdata (eng_wdata),
    .busy      (busy),
    .done      (done),
    .stat_cnt  (stat_cnt),
    .stat_uncor(stat_uncor)
  );

  // the engine owns the RAM port while busy; host access only when idle
  assign ram_we    = busy ? eng_we    : host_we;
  assign ram_addr  = busy ? eng_addr  : host_addr;
  assign ram_wdata = busy ? eng_wdata : host_wdata;

  rsp_byte_ram #(.DEPTH(BLK_BYTES), .AW(AW), .DW(8)) ram_i (
    .clk  (clk),
    .we   (ram_we),
    .addr (ram_addr),
    .wdata(ram_wdata),
    .rdata(host_rdata)
  );
endmodule

// File: rtl/rsp_patcher_chk.sv
module rsp_patcher_chk #(
  parameter int SLOTS = 4,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] stat_cnt,
  input logic             stat_uncor,
  input logic             eng_we
);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_at_finish_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_start_taken_R8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  assert_idle_no_engine_write_R8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !eng_we);

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (stat_cnt <= CNT_W'(SLOTS)));

  assert_uncor_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (done && stat_uncor) |-> (stat_cnt == '0));
endmodule

bind rsp_patcher rsp_patcher_chk #(.SLOTS(SLOTS)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .stat_cnt  (stat_cnt),
  .stat_uncor(stat_uncor),
  .eng_we    (eng_we)
);

// File: tb/rsp_patcher_tb_top.sv
module rsp_patcher_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BYTES  = 512;
  localparam int SYM_W  = 9;
  localparam int IDX_W  = 10;
  localparam int SLOTS  = 4;
  localparam int AW     = 9;
  localparam int CNT_W  = 3;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic start = 1'b0;
  logic [CNT_W-1:0] err_cnt = '0;
  logic err_uncor = 1'b0;
  logic [SLOTS*IDX_W-1:0] err_idx = '0;
  logic [SLOTS*SYM_W-1:0] err_mask = '0;
  logic busy, done, stat_uncor;
  logic [CNT_W-1:0] stat_cnt;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;
  logic [7:0] model [BYTES];

  always #(CLK_PERIOD/2) clk = ~clk;

  rsp_patcher #(.BLK_BYTES(BYTES), .SYM_W(SYM_W), .IDX_W(IDX_W), .SLOTS(SLOTS)) dut_i (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .start(start),
    .err_cnt(err_cnt), .err_uncor(err_uncor), .err_idx(err_idx),
    .err_mask(err_mask), .busy(busy), .done(done), .stat_cnt(stat_cnt),
    .stat_uncor(stat_uncor)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT && !finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit sym_ok(input int k);
    return (k != 0) && (9 * (k - 1) < BYTES * 8);
  endfunction

  function automatic void model_apply(input int k, input logic [SYM_W-1:0] m);
    if (!sym_ok(k)) return;
    for (int b = 0; b < SYM_W; b++) begin
      int g;
      g = 9 * (k - 1) + b;
      if (g < BYTES * 8 && m[b]) model[g / 8][g % 8] = ~model[g / 8][g % 8];
    end
  endfunction

  task automatic host_write(input int a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(input int a, output logic [7:0] d);
    @(negedge clk);
    host_addr = AW'(a);
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic compare_all(input string req);
    for (int a = 0; a < BYTES; a++) begin
      logic [7:0] d;
      host_read(a, d);
      chk(d === model[a], req, $sformatf("byte %0d", a), int'(d), int'(model[a]));
    end
  endtask

  // runs one patch job from err_idx/err_mask; poke issues a start and a host write mid-run
  task automatic run_op(input int cnt, input bit unc, input bit poke, input string req);
    int lat, app, n;
    lat = 1; app = 0;
    if (!unc && cnt >= 1 && cnt <= SLOTS) begin
      for (int s = cnt - 1; s >= 0; s--) begin
        int k;
        k = int'(err_idx[s*IDX_W +: IDX_W]);
        if (sym_ok(k)) begin
          lat += 6; app++;
          model_apply(k, err_mask[s*SYM_W +: SYM_W]);
        end else lat += 1;
      end
    end
    @(negedge clk);
    err_cnt = CNT_W'(cnt); err_uncor = unc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    chk(busy === 1'b1, "R8", "busy after start", int'(busy), 1);
    while (n < 200) begin
      if (done === 1'b1) break;
      @(negedge clk);
      n++;
      if (poke && n == 3) begin
        start = 1'b1; err_uncor = 1'b1; err_cnt = '0;
        host_we = 1'b1; host_addr = AW'(3); host_wdata = ~model[3];
      end
      if (poke && n == 4) begin
        start = 1'b0; host_we = 1'b0;
      end
    end
    chk(n == lat, "R6", "done latency", n, lat);
    chk(stat_cnt == CNT_W'(app), "R7", "applied count", int'(stat_cnt), app);
    chk(stat_uncor == unc, unc ? "R5" : "R7", "uncor status", int'(stat_uncor), int'(unc));
    if (unc) chk(stat_cnt == '0, "R5", "count when uncorrectable", int'(stat_cnt), 0);
    @(negedge clk);
    chk(done === 1'b0, "R6", "done single cycle", int'(done), 0);
    chk(busy === 1'b0, "R6", "busy low after done", int'(busy), 0);
    if (poke) chk(n == lat, "R8", "start while busy ignored", n, lat);
  endtask

  task automatic set_slot(input int s, input int k, input int m);
    err_idx[s*IDX_W +: IDX_W] = IDX_W'(k);
    err_mask[s*SYM_W +: SYM_W] = SYM_W'(m);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(busy === 1'b0, "R9", "busy", int'(busy), 0);
    chk(done === 1'b0, "R9", "done", int'(done), 0);
    chk(stat_cnt === '0, "R9", "stat_cnt", int'(stat_cnt), 0);
    chk(stat_uncor === 1'b0, "R9", "stat_uncor", int'(stat_uncor), 0);

    // R8 fill and read back while idle
    for (int a = 0; a < BYTES; a++) begin
      model[a] = 8'((a * 13 + 7) & 8'hff);
      host_write(a, model[a]);
    end
    compare_all("R8");

    // R2 truncated last symbol: only bit 7 of byte 511 flips
    set_slot(0, 456, 9'h1ff);
    run_op(1, 1'b0, 1'b0, "R2");
    host_read(511, d);
    chk(d === model[511], "R2", "byte 511", int'(d), int'(model[511]));
    host_read(510, d);
    chk(d === model[510], "R2", "byte 510 untouched", int'(d), int'(model[510]));

    // R1 R3 R4 sweep of every index, upper slots hold live indices that must be ignored
    for (int k = 0; k <= 520; k++) begin
      set_slot(0, k, (k * 37 + 1) & 9'h1ff);
      set_slot(1, 5, 9'h0ff);
      set_slot(2, 100, 9'h155);
      set_slot(3, 200, 9'h1aa);
      run_op(1, 1'b0, 1'b0, "R1");
    end
    compare_all("R1");

    // R4 full four-slot run, neighbouring symbols sharing bytes
    set_slot(0, 10, 9'h1ff); set_slot(1, 11, 9'h101);
    set_slot(2, 455, 9'h0f0); set_slot(3, 456, 9'h003);
    run_op(4, 1'b0, 1'b0, "R4");
    // R4 count 3 leaves slot 3 alone
    set_slot(3, 2, 9'h1ff);
    run_op(3, 1'b0, 1'b0, "R4");
    // R4 count 0 and count 5 apply nothing
    run_op(0, 1'b0, 1'b0, "R4");
    run_op(5, 1'b0, 1'b0, "R4");
    // R5 uncorrectable
    run_op(4, 1'b1, 1'b0, "R5");
    // R3 mixed invalid slots
    set_slot(0, 0, 9'h1ff); set_slot(1, 600, 9'h1ff);
    set_slot(2, 457, 9'h1ff); set_slot(3, 1, 9'h1ff);
    run_op(4, 1'b0, 1'b0, "R3");
    // R1 same symbol twice cancels
    set_slot(0, 77, 9'h0a5); set_slot(1, 77, 9'h0a5);
    run_op(2, 1'b0, 1'b0, "R1");
    // R8 start and host write during busy ignored
    set_slot(0, 3, 9'h1ff); set_slot(1, 4, 9'h1ff);
    set_slot(2, 300, 9'h011); set_slot(3, 301, 9'h1c0);
    run_op(4, 1'b0, 1'b1, "R8");
    host_read(3, d);
    chk(d === model[3], "R8", "host write while busy", int'(d), int'(model[3]));
    compare_all("R1");

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule